// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Flags

This block watches over software by counting edges of one tap of a free-running timebase counter that lives outside it. Software starts the watchdog by writing a 0 to the control bit of an 8-bit register. Every later 0-write services it. If software does not service it in time, the block sends a one-clock reset request to the system reset sequencer. Once the watchdog runs, software cannot stop it. Only a system reset, meaning power-on, the external pin, a software reset request or the watchdog's own overflow, returns it to the stopped state.

The same register reports the cause of the most recent resets. Reading it returns the flags and then clears them. The timeout is measured in periods of the selected tap. A start or a service zeroes the edge counter but leaves the phase of the tap alone. The delay therefore lands between 3.5 and 4.5 tap periods after the write.

The register has no address. The bus is one write strobe with write data and one read strobe with combinational read data.

Top module: `wdt_cause_top`

## Requirements
- R1: Power-on reset (`porRstN` low) leaves the watchdog stopped with `wdtRstReq` low. The first read then returns 0x87: bit7 power-on flag = 1, bit6 = 0, bits 5..3 = 0, and bits 2..0 = 111, since the write-only bits always read as ones.
- R2: While stopped, the block never raises `wdtRstReq`, whatever the timebase does.
- R3: A write with bit2 = 0 while stopped starts the watchdog. Unless it is serviced, `wdtRstReq` follows 3.5 to 4.5 periods of the selected tap after that write. The block counts four rising edges of the tap and then fires on the next falling edge.
- R4: Write bits 1:0 select the tap: 00 selects `tbCount[TAP0]`, 01 selects TAP1, 10 selects TAP2 and 11 selects TAP3. A tap bit k has a period of 2^(k+1) clocks.
- R5: A write with bit2 = 0 while running services the watchdog. Regular servicing within 3.5 tap periods prevents any reset. After the last service, the timeout restarts from that write.
- R6: A write with bit2 = 1 neither starts nor services the watchdog.
- R7: Only a start or a service write samples the interval bits, and its own bits 1:0 set the interval from then on. Interval bits written with bit2 = 1 do not change the running interval.
- R8: On overflow, `wdtRstReq` is high for exactly one clock. The watchdog flag (bit5) is set and the watchdog stops. The next 0-write starts it afresh.
- R9: An `extRstReq` pulse sets the external flag (bit4) and stops the watchdog. It leaves the other flags as they are.
- R10: A `swRstReq` pulse sets the software flag (bit3) and stops the watchdog. It leaves the other flags as they are.
- R11: A read returns the current flags and clears bits 7 and 5..3 on the following clock. A reset event in that same clock still sets its own flag.
- R12: Power-on reset sets bit7 and clears bits 5..3, whatever they held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Asynchronous power-on reset, active low |
| extRstReq | input | 1 | One-clock request from the external reset pin |
| swRstReq | input | 1 | One-clock software reset request |
| tbCount | input | TB_W | Free-running timebase counter value |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 8 | Write data; bit2 is the control bit, bits 1:0 are the interval |
| regRd | input | 1 | Register read strobe; clears the cause flags |
| regRdata | output | 8 | Read data {por, 0, wdt, ext, sw, 111} |
| wdtRstReq | output | 1 | One-clock watchdog reset request |

## Verification
Read data is combinational, so the bench samples it in the same cycle as the read strobe. The cleared flags are due one clock after the strobe, and a flag set by a reset event is due one clock after that event. The timeout is due 3.5 to 4.5 tap periods after the start or service edge, plus one register stage for the edge detector and one for the output pulse. The bench timestamps the write edge and the pulse with a shared cycle counter and accepts a window widened by three clocks on each side. Pulse width and the absence of pulses are checked by counting pulses over whole intervals, not by sampling single cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic       restart;  // start or service: zero the count, load interval
    logic       run;      // watchdog running and no reset event this cycle
    logic [1:0] sel;      // interval to load on restart
  } wdtStrobe_t;

  localparam int CTL_BIT = 2;
  localparam logic [2:0] WO_READ = 3'b111;
endpackage

// File: rtl/wdt_dp.sv
module wdt_dp
  import wdt_pkg::*;
#(
  parameter int TB_W = 19,
  parameter int TAP0 = 11,
  parameter int TAP1 = 13,
  parameter int TAP2 = 15,
  parameter int TAP3 = 18
) (
  input  logic            clk,
  input  logic            porRstN,
  input  logic [TB_W-1:0] tbCount,
  input  wdtStrobe_t      ctl,
  output logic            wdtPulse
);
  localparam int NTAP = 4;
  localparam int TAP_IDX [NTAP] = '{TAP0, TAP1, TAP2, TAP3};

  logic [NTAP-1:0] tapVec;
  logic [1:0]      actSel;
  logic [1:0]      edgeCnt;
  logic            tapPrev;
  logic            pend;
  logic            tap;
  logic            rise;
  logic            fall;

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    assign tapVec[i] = tbCount[TAP_IDX[i]];
  end

  logic unusedTb;
  assign unusedTb = ^tbCount;

  assign tap  = tapVec[actSel];
  assign rise = tap & ~tapPrev;
  assign fall = ~tap & tapPrev;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      actSel   <= 2'b11;
      edgeCnt  <= '0;
      tapPrev  <= 1'b0;
      pend     <= 1'b0;
      wdtPulse <= 1'b0;
    end else begin
      wdtPulse <= 1'b0;
      if (ctl.restart) begin
        actSel  <= ctl.sel;
        edgeCnt <= '0;
        pend    <= 1'b0;
        tapPrev <= tapVec[ctl.sel];
      end else begin
        tapPrev <= tap;
        if (!ctl.run) begin
          edgeCnt <= '0;
          pend    <= 1'b0;
        end else if (rise) begin
          edgeCnt <= edgeCnt + 2'd1;
          if (edgeCnt == 2'd3) pend <= 1'b1;
        end else if (fall && pend) begin
          wdtPulse <= 1'b1;
          pend     <= 1'b0;
          edgeCnt  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       porRstN,
  input  logic       extRstReq,
  input  logic       swRstReq,
  input  logic       regWr,
  input  logic [7:0] regWdata,
  input  logic       regRd,
  input  logic       wdtPulse,
  output wdtStrobe_t ctl,
  output logic [7:0] regRdata
);
  logic running;
  logic halt;
  logic ctlWrite;
  logic porFlag, wdtFlag, extFlag, swFlag;

  logic unusedWd;
  assign unusedWd = ^regWdata[7:3];

  assign halt     = extRstReq | swRstReq | wdtPulse;
  assign ctlWrite = regWr & ~regWdata[CTL_BIT];

  assign ctl.restart = ctlWrite & ~halt;
  assign ctl.run     = running & ~halt;
  assign ctl.sel     = regWdata[1:0];

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      running <= 1'b0;
      porFlag <= 1'b1;
      wdtFlag <= 1'b0;
      extFlag <= 1'b0;
      swFlag  <= 1'b0;
    end else begin
      if (halt)          running <= 1'b0;
      else if (ctlWrite) running <= 1'b1;
      porFlag <= porFlag & ~regRd;
      wdtFlag <= wdtPulse  | (wdtFlag & ~regRd);
      extFlag <= extRstReq | (extFlag & ~regRd);
      swFlag  <= swRstReq  | (swFlag  & ~regRd);
    end
  end

  assign regRdata = {porFlag, 1'b0, wdtFlag, extFlag, swFlag, WO_READ};
endmodule

// File: rtl/wdt_cause_top.sv
module wdt_cause_top
  import wdt_pkg::*;
#(
  parameter int TB_W = 19,
  parameter int TAP0 = 11,
  parameter int TAP1 = 13,
  parameter int TAP2 = 15,
  parameter int TAP3 = 18
) (
  input  logic            clk,
  input  logic            porRstN,
  input  logic            extRstReq,
  input  logic            swRstReq,
  input  logic [TB_W-1:0] tbCount,
  input  logic            regWr,
  input  logic [7:0]      regWdata,
  input  logic            regRd,
  output logic [7:0]      regRdata,
  output logic            wdtRstReq
);
  wdtStrobe_t ctl;

  wdt_ctrl u_ctrl (
    .clk       (clk),
    .porRstN   (porRstN),
    .extRstReq (extRstReq),
    .swRstReq  (swRstReq),
    .regWr     (regWr),
    .regWdata  (regWdata),
    .regRd     (regRd),
    .wdtPulse  (wdtRstReq),
    .ctl       (ctl),
    .regRdata  (regRdata)
  );

  wdt_dp #(
    .TB_W (TB_W), .TAP0 (TAP0), .TAP1 (TAP1), .TAP2 (TAP2), .TAP3 (TAP3)
  ) u_dp (
    .clk      (clk),
    .porRstN  (porRstN),
    .tbCount  (tbCount),
    .ctl      (ctl),
    .wdtPulse (wdtRstReq)
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk (
  input logic       clk,
  input logic       porRstN,
  input logic       extRstReq,
  input logic       swRstReq,
  input logic       regRd,
  input logic [7:0] regRdata,
  input logic       wdtRstReq
);
  // R8
  pulse_width_chk: assert property (@(posedge clk) disable iff (!porRstN)
    wdtRstReq |=> !wdtRstReq);
  // R8
  wdt_flag_chk: assert property (@(posedge clk) disable iff (!porRstN)
    wdtRstReq |=> regRdata[5]);
  // R9
  ext_flag_chk: assert property (@(posedge clk) disable iff (!porRstN)
    extRstReq |=> regRdata[4]);
  // R9
  ext_stop_chk: assert property (@(posedge clk) disable iff (!porRstN)
    extRstReq |=> !wdtRstReq);
  // R10
  sw_flag_chk: assert property (@(posedge clk) disable iff (!porRstN)
    swRstReq |=> (regRdata[3] && !wdtRstReq));
  // R11
  read_clear_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (regRd && !extRstReq && !swRstReq && !wdtRstReq) |=> (regRdata[7:3] == 5'd0));
endmodule

bind wdt_cause_top wdt_chk u_chk (
  .clk       (clk),
  .porRstN   (porRstN),
  .extRstReq (extRstReq),
  .swRstReq  (swRstReq),
  .regRd     (regRd),
  .regRdata  (regRdata),
  .wdtRstReq (wdtRstReq)
);

// File: tb/wdt_cause_top_tb.sv
module wdt_cause_top_tb;
  localparam int TB_W = 8;
  localparam int TP0 = 2, TP1 = 3, TP2 = 4, TP3 = 5;

  logic       clk = 1'b0;
  logic       porRstN = 1'b0;
  logic       extRstReq = 1'b0;
  logic       swRstReq = 1'b0;
  logic [TB_W-1:0] tbCount = '0;
  logic       regWr = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic       regRd = 1'b0;
  logic [7:0] regRdata;
  logic       wdtRstReq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int pulseCount = 0;
  int lastPulse = 0;
  int wideCount = 0;
  logic prevPulse = 1'b0;

  wdt_cause_top #(
    .TB_W (TB_W), .TAP0 (TP0), .TAP1 (TP1), .TAP2 (TP2), .TAP3 (TP3)
  ) u_dut (
    .clk (clk), .porRstN (porRstN), .extRstReq (extRstReq), .swRstReq (swRstReq),
    .tbCount (tbCount), .regWr (regWr), .regWdata (regWdata), .regRd (regRd),
    .regRdata (regRdata), .wdtRstReq (wdtRstReq)
  );

  always #2 clk = ~clk;

  // free-running timebase and pulse bookkeeping (sequencer model)
  always @(posedge clk) begin
    tbCount <= tbCount + 1'b1;
    cyc <= cyc + 1;
    prevPulse <= wdtRstReq;
    if (wdtRstReq) begin
      pulseCount <= pulseCount + 1;
      lastPulse <= cyc;
      if (prevPulse) wideCount <= wideCount + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wrReg(input logic [7:0] d, output int stamp);
    @(negedge clk);
    regWr = 1'b1; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
    stamp = cyc - 1;
  endtask

  task automatic rdReg(output logic [7:0] d);
    @(negedge clk);
    regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic waitPulse(input int startCount, input int maxCyc);
    for (int i = 0; i < maxCyc; i++) begin
      if (pulseCount != startCount) break;
      @(negedge clk);
    end
  endtask

  task automatic checkWindow(input int t0, input int tapBit, input string req);
    int per, lo, hi, el;
    per = 2 ** (tapBit + 1);
    lo = (7 * per) / 2 - 3;
    hi = (9 * per) / 2 + 3;
    el = lastPulse - t0;
    check(el >= lo && el <= hi, req, el, (lo + hi) / 2);
  endtask

  task automatic powerOn();
    porRstN = 1'b0;
    idle(3);
    porRstN = 1'b1;
    idle(2);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    powerOn();
    check(wdtRstReq == 1'b0, "R1 pulse low", wdtRstReq, 0);
    rdReg(d);
    check(d == 8'h87, "R1 read after POR", d, 8'h87);
    rdReg(d);
    check(d == 8'h07, "R11 flags cleared by read", d, 8'h07);
  endtask

  task automatic t_stopped();
    int pc, t;
    pc = pulseCount;
    idle(400);
    check(pulseCount == pc, "R2 no pulse while stopped", pulseCount - pc, 0);
    wrReg(8'h04, t);
    idle(400);
    check(pulseCount == pc, "R6 writing 1 does not start", pulseCount - pc, 0);
  endtask

  task automatic t_start(input logic [1:0] sel, input int tapBit, input string req);
    int pc, t;
    logic [7:0] d;
    pc = pulseCount;
    wrReg({6'b0, sel}, t);
    waitPulse(pc, 400);
    check(pulseCount == pc + 1, req, pulseCount - pc, 1);
    checkWindow(t, tapBit, req);
    idle(2);
    rdReg(d);
    check(d == 8'h27, "R8 watchdog flag", d, 8'h27);
  endtask

  task automatic t_overflowStops();
    int pc, t;
    pc = pulseCount;
    wrReg(8'h00, t);
    waitPulse(pc, 400);
    idle(400);
    check(pulseCount == pc + 1, "R8 stops after overflow", pulseCount - pc, 1);
    check(wideCount == 0, "R8 pulse one clock", wideCount, 0);
    pc = pulseCount;
    wrReg(8'h00, t);
    waitPulse(pc, 400);
    checkWindow(t, TP0, "R8 restart after overflow");
  endtask

  task automatic t_service();
    int pc, t;
    pc = pulseCount;
    wrReg(8'h00, t);
    for (int i = 0; i < 20; i++) begin
      idle(14);
      wrReg(8'h00, t);
    end
    check(pulseCount == pc, "R5 serviced: no reset", pulseCount - pc, 0);
    waitPulse(pc, 400);
    checkWindow(t, TP0, "R5 timeout from last service");
  endtask

  task automatic t_oneNoService();
    int pc, t, tx;
    pc = pulseCount;
    wrReg(8'h00, t);
    idle(10);
    wrReg(8'h04, tx);
    idle(5);
    wrReg(8'h04, tx);
    waitPulse(pc, 400);
    checkWindow(t, TP0, "R6 writing 1 does not service");
  endtask

  task automatic t_selLater();
    int pc, t, tx;
    pc = pulseCount;
    wrReg(8'h00, t);
    idle(8);
    wrReg(8'h07, tx);
    waitPulse(pc, 400);
    checkWindow(t, TP0, "R7 interval kept on 1-write");
    pc = pulseCount;
    wrReg(8'h00, t);
    idle(8);
    wrReg(8'h03, t);
    waitPulse(pc, 600);
    checkWindow(t, TP3, "R7 interval from service write");
  endtask

  task automatic t_extOrSw(input bit useExt);
    int pc, t;
    logic [7:0] d;
    rdReg(d);
    pc = pulseCount;
    wrReg(8'h00, t);
    idle(10);
    @(negedge clk);
    if (useExt) extRstReq = 1'b1; else swRstReq = 1'b1;
    @(negedge clk);
    extRstReq = 1'b0; swRstReq = 1'b0;
    rdReg(d);
    if (useExt) check(d == 8'h17, "R9 external flag only", d, 8'h17);
    else        check(d == 8'h0F, "R10 software flag only", d, 8'h0F);
    idle(400);
    if (useExt) check(pulseCount == pc, "R9 stops watchdog", pulseCount - pc, 0);
    else        check(pulseCount == pc, "R10 stops watchdog", pulseCount - pc, 0);
    wrReg(8'h00, t);
    waitPulse(pc, 400);
    if (useExt) checkWindow(t, TP0, "R9 next 0-write starts");
    else        checkWindow(t, TP0, "R10 next 0-write starts");
    idle(2);
    rdReg(d);
  endtask

  task automatic t_readRace();
    logic [7:0] d;
    @(negedge clk);
    regRd = 1'b1; extRstReq = 1'b1;
    @(negedge clk);
    regRd = 1'b0; extRstReq = 1'b0;
    rdReg(d);
    check(d == 8'h17, "R11 event beats read clear", d, 8'h17);
  endtask

  task automatic t_por();
    logic [7:0] d;
    @(negedge clk);
    extRstReq = 1'b1; swRstReq = 1'b1;
    @(negedge clk);
    extRstReq = 1'b0; swRstReq = 1'b0;
    powerOn();
    rdReg(d);
    check(d == 8'h87, "R12 POR clears other flags", d, 8'h87);
  endtask

  initial begin
    t_reset();
    t_stopped();
    t_start(2'b00, TP0, "R3 start and timeout sel00");
    t_start(2'b01, TP1, "R4 timeout sel01");
    t_start(2'b10, TP2, "R4 timeout sel10");
    t_start(2'b11, TP3, "R4 timeout sel11");
    t_overflowStops();
    t_service();
    t_oneNoService();
    t_selLater();
    t_extOrSw(1'b1);
    t_extOrSw(1'b0);
    t_readRace();
    t_por();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule